// File: doc/BRIEF.md
# Receive Ring Buffer Frame Writer

This block sits after a receive MAC that has already checked frames. Each frame it is given is stored in a circular byte buffer in system memory, where a host picks it up later. A frame is announced by a single header beat that carries its byte count (including the 4-byte FCS) and a 16-bit receive status word. The block writes a 4-byte descriptor word, then the frame bytes one per cycle through a plain byte-wide RAM write port. It then moves its write offset to the next 32-bit boundary. Offsets wrap at the end of the ring, which can be 8, 16 or 32 KiB.

The host owns a read pointer register. It writes that register as the offset it has finished with minus 16. The block works out how much of the ring is free from the two pointers. If a frame would run into data the host has not yet taken, the block swallows the frame without writing it, raises an overflow status bit and counts the miss. A command register shows a buffer-empty flag and takes a pointer-reset command.

Register map, word addressed on `reg_addr`:
- 0: command.
- 1: read pointer.
- 2: interrupt status.
- 3: missed-frame counter.
- 4: ring size index.

A read returns its data on `reg_rdata` one cycle after `reg_rd`. Header beats are taken only while `in_hdr_ready` is high. Data bytes are taken only while `in_ready` is high.

Top module: `rxring_writer`

## Requirements
- R1: After reset:
  - no memory write is issued;
  - the command register reads bit 0 (empty) as 1;
  - the read pointer register reads 0xFFF0;
  - interrupt status bit 4 reads 0;
  - the missed-frame counter reads 0.
- R2: Every stored frame starts with a 32-bit header written at the frame's start offset, least significant byte first. Bits 15:0 are the status word exactly as supplied (for example bit 0 good, bit 13 broadcast, bit 14 address match). Bits 31:16 are the supplied byte count, FCS included.
- R3: Frame byte i is written once, in arrival order, at start offset + 4 + i modulo the ring size. Nothing is written for the alignment padding.
- R4: The first frame after reset starts at offset 0. Each next frame starts at start + 4 + count, rounded up to a multiple of 4, modulo the ring size.
- R5: A frame whose bytes pass the last ring offset continues at offset 0.
- R6: Command bit 0 reads 1 exactly when the write offset equals (read pointer + 16) modulo the ring size.
- R7: A frame that does not fit is dropped, with all of the following:
  - no memory write is made for it;
  - its data bytes are still consumed;
  - interrupt status bit 4 is set;
  - the 24-bit missed-frame counter increments by one.
- R8: Writing a 1 to bit 4 of the interrupt status register clears the overflow bit. Writing 0 there leaves it set.
- R9: Any write to the missed-frame counter address clears the counter to 0.
- R10: Bits 1:0 of the ring size register select a ring of 8192 << index bytes. Index 3 behaves as index 2.
- R11: Writing the command register with bit 4 set returns the write offset to 0 and the read pointer to 0xFFF0 (consumed offset 0). The overflow bit and the missed-frame counter are not changed.
- R12: A frame is accepted only when roundup4(count + 4) is strictly less than the free space. Free space is the ring size minus ((write offset − consumed offset) modulo ring size). An exact fit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_hdr_valid | input | 1 | Header beat for the next frame is present |
| in_hdr_ready | output | 1 | Block can take a header beat |
| in_len | input | 16 | Frame byte count including FCS |
| in_status | input | 16 | Receive status word stored in the header |
| in_valid | input | 1 | Frame data byte present |
| in_ready | output | 1 | Block takes a data byte this cycle |
| in_byte | input | 8 | Frame data byte |
| in_last | input | 1 | Final byte of the frame |
| mem_we | output | 1 | Ring memory byte write strobe |
| mem_addr | output | 15 | Ring byte offset for the write |
| mem_wdata | output | 8 | Byte to write |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |

## Verification
The hardest case to reach from the ports is a frame that fills the free space exactly, so that accepting it would make a full ring look empty. To get there, the bench stops moving the read pointer and stores several full-size frames, leaving exactly 672 free bytes. It then offers one frame needing 672 bytes, which must be dropped, and one needing 668, which must be stored. Other sequences carry the write offset across the 8 KiB end mid-frame, and across the old end of a ring resized to 16 KiB, while a behavioural model tracks every expected byte write.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_HDR,
    WS_DATA,
    WS_DROP
  } wr_state_e;

  localparam logic [2:0] RA_CMD    = 3'd0;
  localparam logic [2:0] RA_RDPTR  = 3'd1;
  localparam logic [2:0] RA_ISTAT  = 3'd2;
  localparam logic [2:0] RA_MISSED = 3'd3;
  localparam logic [2:0] RA_CFG    = 3'd4;

  localparam int unsigned CMD_EMPTY_BIT = 0;
  localparam int unsigned CMD_RESET_BIT = 4;
  localparam int unsigned IST_OVF_BIT   = 4;

  localparam int unsigned HDR_BYTES = 4;
  localparam int unsigned PTR_BIAS  = 16;
  localparam int unsigned RDW       = 32;

endpackage

// File: rtl/rxr_space.sv
module rxr_space
  import rxr_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 13,
  parameter int unsigned MAX_IDX   = 2,
  parameter int unsigned PTRW      = 16,
  parameter int unsigned LENW      = 16,
  localparam int unsigned AW       = BASE_LOG2 + MAX_IDX,
  localparam int unsigned IDXW     = (MAX_IDX > 0) ? $clog2(MAX_IDX + 1) : 1
) (
  input  logic [IDXW-1:0] size_idx,
  input  logic [AW-1:0]   wr_off,
  input  logic [PTRW-1:0] rd_ptr,
  input  logic [LENW-1:0] len,
  output logic [AW-1:0]   ring_mask,
  output logic            empty,
  output logic            fits
);

  localparam int unsigned NW = LENW + 2;
  localparam int unsigned CW = (NW > AW + 1) ? NW : AW + 1;

  logic [IDXW-1:0] idx_c;
  logic [AW-1:0]   rd_off;
  logic [AW-1:0]   used;
  logic [AW:0]     size_b;
  logic [AW:0]     free_b;
  logic [NW-1:0]   need;

  always_comb begin
    idx_c     = (size_idx > IDXW'(MAX_IDX)) ? IDXW'(MAX_IDX) : size_idx;
    ring_mask = {AW{1'b1}} >> (IDXW'(MAX_IDX) - idx_c);
    rd_off    = AW'(rd_ptr + PTRW'(PTR_BIAS)) & ring_mask;
    used      = (wr_off - rd_off) & ring_mask;
    size_b    = {1'b0, ring_mask} + (AW+1)'(1);
    free_b    = size_b - {1'b0, used};
    need      = (NW'(len) + NW'(HDR_BYTES + 3)) & ~NW'(3);
    fits      = CW'(need) < CW'(free_b);
    empty     = (wr_off == rd_off);
  end

endmodule

// File: rtl/rxr_regs.sv
module rxr_regs
  import rxr_pkg::*;
#(
  parameter int unsigned PTRW  = 16,
  parameter int unsigned IDXW  = 2,
  parameter int unsigned MISSW = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [2:0]      reg_addr,
  input  logic [PTRW-1:0] reg_wdata,
  input  logic            empty,
  input  logic            drop_evt,
  output logic [PTRW-1:0] rd_ptr,
  output logic [IDXW-1:0] size_idx,
  output logic            soft_rst,
  output logic            ovf_flag,
  output logic [RDW-1:0]  reg_rdata
);

  localparam logic [PTRW-1:0] PTR_INIT = PTRW'(0) - PTRW'(PTR_BIAS);

  logic [MISSW-1:0] missed;
  logic [RDW-1:0]   rd_mux;
  logic             wr_ptr_sel;
  logic             wr_ist_sel;
  logic             wr_mis_sel;
  logic             wr_cfg_sel;

  always_comb begin
    soft_rst   = reg_wr && (reg_addr == RA_CMD) && reg_wdata[CMD_RESET_BIT];
    wr_ptr_sel = reg_wr && (reg_addr == RA_RDPTR);
    wr_ist_sel = reg_wr && (reg_addr == RA_ISTAT);
    wr_mis_sel = reg_wr && (reg_addr == RA_MISSED);
    wr_cfg_sel = reg_wr && (reg_addr == RA_CFG);
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_CMD:    rd_mux[CMD_EMPTY_BIT] = empty;
      RA_RDPTR:  rd_mux = RDW'(rd_ptr);
      RA_ISTAT:  rd_mux[IST_OVF_BIT] = ovf_flag;
      RA_MISSED: rd_mux = RDW'(missed);
      RA_CFG:    rd_mux = RDW'(size_idx);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr    <= PTR_INIT;
      size_idx  <= '0;
      ovf_flag  <= 1'b0;
      missed    <= '0;
      reg_rdata <= '0;
    end else begin
      if (soft_rst)
        rd_ptr <= PTR_INIT;
      else if (wr_ptr_sel)
        rd_ptr <= reg_wdata;

      if (wr_cfg_sel)
        size_idx <= reg_wdata[IDXW-1:0];

      if (drop_evt)
        ovf_flag <= 1'b1;
      else if (wr_ist_sel && reg_wdata[IST_OVF_BIT])
        ovf_flag <= 1'b0;

      if (wr_mis_sel)
        missed <= drop_evt ? MISSW'(1) : '0;
      else if (drop_evt)
        missed <= missed + MISSW'(1);

      if (reg_rd)
        reg_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/rxr_writer.sv
module rxr_writer
  import rxr_pkg::*;
#(
  parameter int unsigned AW   = 15,
  parameter int unsigned LENW = 16,
  parameter int unsigned STW  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            soft_rst,
  input  logic [AW-1:0]   ring_mask,
  input  logic            fits,
  input  logic            hdr_valid,
  input  logic [LENW-1:0] hdr_len,
  input  logic [STW-1:0]  hdr_status,
  output logic            hdr_ready,
  input  logic            in_valid,
  input  logic [7:0]      in_byte,
  input  logic            in_last,
  output logic            in_ready,
  output logic [AW-1:0]   wr_off,
  output logic            drop_evt,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [7:0]      mem_wdata
);

  localparam int unsigned HW = LENW + STW;
  localparam int unsigned NW = LENW + 2;

  wr_state_e       state;
  logic [AW-1:0]   base;
  logic [LENW-1:0] len_q;
  logic [STW-1:0]  stat_q;
  logic [1:0]      hidx;
  logic [LENW-1:0] cnt;
  logic [HW-1:0]   hdr_word;
  logic [NW-1:0]   need_q;
  logic [AW-1:0]   next_wr;

  always_comb begin
    hdr_ready = (state == WS_IDLE);
    in_ready  = (state == WS_DATA) || (state == WS_DROP);
    drop_evt  = hdr_ready && hdr_valid && !fits;
    hdr_word  = {len_q, stat_q};
    need_q    = (NW'(len_q) + NW'(HDR_BYTES + 3)) & ~NW'(3);
    next_wr   = (base + AW'(need_q)) & ring_mask;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      state     <= WS_IDLE;
      wr_off    <= '0;
      base      <= '0;
      len_q     <= '0;
      stat_q    <= '0;
      hidx      <= '0;
      cnt       <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      case (state)
        WS_IDLE: begin
          if (hdr_valid) begin
            base   <= wr_off;
            len_q  <= hdr_len;
            stat_q <= hdr_status;
            hidx   <= '0;
            cnt    <= '0;
            state  <= fits ? WS_HDR : WS_DROP;
          end
        end
        WS_HDR: begin
          mem_we    <= 1'b1;
          mem_addr  <= (base + AW'(hidx)) & ring_mask;
          mem_wdata <= hdr_word[{hidx, 3'b000} +: 8];
          hidx      <= hidx + 2'd1;
          if (hidx == 2'd3)
            state <= WS_DATA;
        end
        WS_DATA: begin
          if (in_valid) begin
            mem_we    <= 1'b1;
            mem_addr  <= (base + AW'(HDR_BYTES) + AW'(cnt)) & ring_mask;
            mem_wdata <= in_byte;
            cnt       <= cnt + LENW'(1);
            if (in_last) begin
              wr_off <= next_wr;
              state  <= WS_IDLE;
            end
          end
        end
        WS_DROP: begin
          if (in_valid && in_last)
            state <= WS_IDLE;
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxr_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 13,
  parameter int unsigned MAX_IDX   = 2,
  parameter int unsigned PTRW      = 16,
  parameter int unsigned LENW      = 16,
  parameter int unsigned STW       = 16,
  parameter int unsigned MISSW     = 24,
  localparam int unsigned AW       = BASE_LOG2 + MAX_IDX,
  localparam int unsigned IDXW     = (MAX_IDX > 0) ? $clog2(MAX_IDX + 1) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_hdr_valid,
  output logic            in_hdr_ready,
  input  logic [LENW-1:0] in_len,
  input  logic [STW-1:0]  in_status,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [7:0]      in_byte,
  input  logic            in_last,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [2:0]      reg_addr,
  input  logic [PTRW-1:0] reg_wdata,
  output logic [RDW-1:0]  reg_rdata
);

  logic [AW-1:0]   ring_mask;
  logic [AW-1:0]   wr_off;
  logic [PTRW-1:0] rd_ptr;
  logic [IDXW-1:0] size_idx;
  logic            empty;
  logic            fits;
  logic            drop_evt;
  logic            soft_rst;
  logic            ovf_flag;

  rxr_space #(
    .BASE_LOG2 (BASE_LOG2),
    .MAX_IDX   (MAX_IDX),
    .PTRW      (PTRW),
    .LENW      (LENW)
  ) u_space (
    .size_idx  (size_idx),
    .wr_off    (wr_off),
    .rd_ptr    (rd_ptr),
    .len       (in_len),
    .ring_mask (ring_mask),
    .empty     (empty),
    .fits      (fits)
  );

  rxr_regs #(
    .PTRW  (PTRW),
    .IDXW  (IDXW),
    .MISSW (MISSW)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .empty     (empty),
    .drop_evt  (drop_evt),
    .rd_ptr    (rd_ptr),
    .size_idx  (size_idx),
    .soft_rst  (soft_rst),
    .ovf_flag  (ovf_flag),
    .reg_rdata (reg_rdata)
  );

  rxr_writer #(
    .AW   (AW),
    .LENW (LENW),
    .STW  (STW)
  ) u_writer (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .ring_mask  (ring_mask),
    .fits       (fits),
    .hdr_valid  (in_hdr_valid),
    .hdr_len    (in_len),
    .hdr_status (in_status),
    .hdr_ready  (in_hdr_ready),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .in_last    (in_last),
    .in_ready   (in_ready),
    .wr_off     (wr_off),
    .drop_evt   (drop_evt),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );

endmodule

// File: rtl/rxring_writer_chk.sv
module rxring_writer_chk #(
  parameter int unsigned AW = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] ring_mask,
  input logic [AW-1:0] wr_off,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_last,
  input logic          in_hdr_ready,
  input logic          drop_evt,
  input logic          ovf_flag,
  input logic          soft_rst
);

  // R1: first cycle out of reset is quiet
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_we && !in_ready));

  // R5: every write lands inside the selected ring
  p_addr_in_ring_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ((mem_addr & ~ring_mask) == '0));

  // R4: write offset stays dword aligned
  p_wr_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    wr_off[1:0] == 2'b00);

  // R4: write offset moves only at frame end or pointer reset
  p_wr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!(in_valid && in_ready && in_last) && !soft_rst) |=> $stable(wr_off));

  // R7: a dropped frame writes nothing next cycle and raises overflow
  p_drop_flag_r7: assert property (@(posedge clk) disable iff (rst)
    drop_evt |=> (ovf_flag && !mem_we));

  // R11: pointer reset returns write offset to zero
  p_soft_reset_r11: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (wr_off == '0));

  // R3: header and data acceptance never overlap
  p_ready_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(in_hdr_ready && in_ready));

endmodule

bind rxring_writer rxring_writer_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .ring_mask    (ring_mask),
  .wr_off       (wr_off),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_last      (in_last),
  .in_hdr_ready (in_hdr_ready),
  .drop_evt     (drop_evt),
  .ovf_flag     (ovf_flag),
  .soft_rst     (soft_rst)
);

// File: tb/rxring_writer_bench.sv
module rxring_writer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_hdr_valid = 1'b0;
  logic        in_hdr_ready;
  logic [15:0] in_len = '0;
  logic [15:0] in_status = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = '0;
  logic        in_last = 1'b0;
  logic        mem_we;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  always #4 clk = ~clk;

  rxring_writer u_rxring_writer (
    .clk(clk), .rst(rst),
    .in_hdr_valid(in_hdr_valid), .in_hdr_ready(in_hdr_ready),
    .in_len(in_len), .in_status(in_status),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte), .in_last(in_last),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural model state
  int wr_m = 0;
  int rdptr_m = 'hFFF0;
  int idx_m = 0;
  int missed_m = 0;
  int ovf_m = 0;
  int    qa[$];
  int    qd[$];
  string qt[$];

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int rmask();
    return (8192 << idx_m) - 1;
  endfunction

  function automatic int empty_m();
    return (wr_m == ((rdptr_m + 16) & rmask())) ? 1 : 0;
  endfunction

  // compare every memory write against the model's expected stream
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (qa.size() == 0) begin
        chk("R7 unexpected write addr", int'(mem_addr), -1);
      end else begin
        string t;
        int a;
        int d;
        a = qa.pop_front();
        d = qd.pop_front();
        t = qt.pop_front();
        chk(t, int'(mem_addr), a);
        chk(t, int'(mem_wdata), d);
      end
    end
  end

  task automatic reg_write(input logic [2:0] a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d[15:0];
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output int d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = int'(reg_rdata);
  endtask

  task automatic send(input int len, input int st, input int seed, input string tag);
    int m;
    int rd_off;
    int used;
    int freeb;
    int need;
    int hw;
    int i;
    m      = rmask();
    rd_off = (rdptr_m + 16) & m;
    used   = (wr_m - rd_off) & m;
    freeb  = m + 1 - used;
    need   = ((len + 7) / 4) * 4;
    if (need < freeb) begin
      hw = (len << 16) | st;
      for (int k = 0; k < 4; k++) begin
        qa.push_back((wr_m + k) & m);
        qd.push_back((hw >> (8 * k)) & 255);
        qt.push_back({tag, " header"});
      end
      for (int b = 0; b < len; b++) begin
        qa.push_back((wr_m + 4 + b) & m);
        qd.push_back((seed + b * 7) & 255);
        qt.push_back({tag, " data"});
      end
      wr_m = (wr_m + need) & m;
    end else begin
      missed_m++;
      ovf_m = 1;
    end
    @(negedge clk);
    in_hdr_valid = 1'b1; in_len = len[15:0]; in_status = st[15:0];
    @(negedge clk);
    in_hdr_valid = 1'b0;
    i = 0;
    while (i < len) begin
      if (in_ready) begin
        in_valid = 1'b1;
        in_byte  = 8'((seed + i * 7) & 255);
        in_last  = (i == len - 1);
        i++;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic drain(input string tag);
    repeat (3) @(negedge clk);
    chk(tag, qa.size(), 0);
  endtask

  task automatic consume();
    rdptr_m = (wr_m - 16) & 'hFFFF;
    reg_write(3'd1, rdptr_m);
  endtask

  task automatic check_empty(input string tag);
    int d;
    reg_read(3'd0, d);
    chk(tag, d & 1, empty_m());
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    summary();
  end

  initial begin
    int d;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    reg_read(3'd0, d); chk("R1 empty", d & 1, 1);
    reg_read(3'd1, d); chk("R1 rdptr", d, 'hFFF0);
    reg_read(3'd2, d); chk("R1 istat", d, 0);
    reg_read(3'd3, d); chk("R1 missed", d, 0);

    // R2 / R3 / R4 basic frames, second one needs rounding
    send(64, 'h2001, 5, "R2");
    send(61, 'h4001, 9, "R4");
    drain("R3 pending");

    // R6 empty tracks read pointer
    check_empty("R6 not empty");
    consume();
    check_empty("R6 empty");

    // R5 wrap across ring end
    for (int k = 0; k < 5; k++) begin
      send(1500, 'h8001, k, "R4");
      consume();
    end
    send(600, 'h0001, 77, "R5");
    drain("R5 pending");
    consume();
    check_empty("R6 after wrap");

    // R7 / R12 overflow and exact-fit rule
    for (int k = 0; k < 5; k++) send(1500, 'h0001, 20 + k, "R12");
    send(700, 'h0001, 3, "R7");
    drain("R7 no write");
    reg_read(3'd2, d); chk("R7 istat", d, ovf_m << 4);
    reg_read(3'd3, d); chk("R7 missed", d, missed_m);
    send(668, 'h0001, 4, "R12");
    reg_read(3'd3, d); chk("R12 exact fit dropped", d, missed_m);
    send(664, 'h0001, 6, "R12");
    drain("R12 accepted");
    reg_read(3'd3, d); chk("R12 missed", d, missed_m);
    check_empty("R12 not empty");

    // R8 write-one-to-clear
    reg_write(3'd2, 0);
    reg_read(3'd2, d); chk("R8 zero write keeps", d, 'h10);
    reg_write(3'd2, 'h10);
    ovf_m = 0;
    reg_read(3'd2, d); chk("R8 cleared", d, 0);

    // R9 clear on write
    reg_write(3'd3, 'h1234);
    missed_m = 0;
    reg_read(3'd3, d); chk("R9 cleared", d, 0);

    // R11 pointer reset command
    reg_write(3'd0, 'h10);
    wr_m = 0;
    rdptr_m = 'hFFF0;
    reg_read(3'd1, d); chk("R11 rdptr", d, 'hFFF0);
    check_empty("R11 empty");
    send(60, 'h0001, 3, "R11");
    drain("R11 pending");

    // R10 16 KiB ring: no wrap at 8192
    reg_write(3'd4, 1);
    idx_m = 1;
    reg_read(3'd4, d); chk("R10 cfg", d, 1);
    consume();
    for (int k = 0; k < 6; k++) begin
      send(1500, 'h0001, 40 + k, "R10");
      consume();
    end
    drain("R10 pending");
    chk("R10 offset beyond 8K", (wr_m > 8192) ? 1 : 0, 1);
    check_empty("R10 empty");

    summary();
  end

endmodule